// File: doc/BRIEF.md
# Signed-Shift Execution Unit

This block is the combinational result stage of a small 32-bit RISC core. Each cycle it is handed two register operands, the current value of the destination register, an 8-bit immediate field, an operand-source flag and a 4-bit operation code. It returns one 32-bit result, which the core writes back to its register file. Decoding, the register file, memory access and branching all sit outside the block.

The block has two less common features. First, there is only one shift operation. Its amount is signed: a positive amount shifts left, and a negative amount shifts arithmetically right by its magnitude. Second, it supports an 8-bit shift-and-load step. Software can build any 32-bit constant with one load-immediate followed by three shift-and-load steps. Immediate add and immediate shift take a 6-bit signed field. Their source is either the destination register itself or its paired register, selected by a flag.

Top module: `exec_unit`

## Requirements
- R1: Add (code 0) gives opA + opB and subtract (code 1) gives opA - opB, both wrapping modulo 2^32 with no flag outputs.
- R2: Bitwise and (code 2), or (code 3) and xor (code 4) combine opA with opB bit by bit.
- R3: The register shift (code 5) reads opB as a signed 32-bit amount. A positive amount shifts opA left with zero fill. A negative amount shifts opA right arithmetically by the magnitude. An amount of zero returns opA unchanged.
- R4: For any shift whose magnitude is 32 or more, a left shift gives 0 and a right shift gives 32 copies of the source sign bit. This includes an amount of -2^31.
- R5: Signed less-than (code 6) and unsigned less-than (code 7) give 1 when opA < opB under their interpretation and 0 otherwise. Bits 31..1 of the result are always 0.
- R6: Load-immediate (code 8) gives imm8 zero-extended to 32 bits.
- R7: Shift-and-load (code 9) gives (oldRd << 8) + imm8. Starting from a load-immediate of the top byte, three such steps build any 32-bit value, for example 0x87654321.
- R8: Immediate add (code 10) adds imm8[5:0], sign-extended to 32 bits, to the selected source. imm8[7:6] has no effect.
- R9: Immediate shift (code 11) uses imm8[5:0] as a signed amount with the same direction and range rules as R3 and R4, applied to the selected source.
- R10: For codes 10 and 11 the source is oldRd when srcPair is 0 and opA when srcPair is 1. For codes 0 to 8, oldRd has no effect.
- R11: Codes 12 to 15 are unassigned and give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code, values 0 to 11 as listed in the requirements |
| opA | input | 32 | First register operand (the paired register for immediate ops) |
| opB | input | 32 | Second register operand or signed shift amount |
| oldRd | input | 32 | Current value of the destination register |
| imm8 | input | 8 | Immediate field; bits 5..0 serve as the 6-bit signed immediate |
| srcPair | input | 1 | Source flag for immediate add and shift: 1 selects opA, 0 selects oldRd |
| result | output | 32 | Operation result |

## Verification
Two mechanisms act together on the immediate operations: source selection between oldRd and the paired register, and the signed-direction shift with its saturation range. One operation therefore exercises both.

The bench always drives opA and oldRd with different values and flips srcPair across both immediate operations. It also walks the 6-bit amount through +31, -1 and -32. A wrong source choice, a wrong direction or a wrong saturation each gives a result that differs from the bench model's, and the bench compares every such result.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SHF   = 4'd5,
    OP_SLT   = 4'd6,
    OP_SLTU  = 4'd7,
    OP_LDI   = 4'd8,
    OP_SHLDI = 4'd9,
    OP_ADDI  = 4'd10,
    OP_SHFI  = 4'd11
  } opCode_e;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_ARITH,
    RS_LOGIC,
    RS_SHIFT,
    RS_CMP,
    RS_IMM
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR
  } logicOp_e;

  typedef struct packed {
    resSel_e  resSel;
    logicOp_e logicOp;
    logic     doSub;
    logic     cmpSigned;
    logic     useImm6;
    logic     immSource;
    logic     shiftLoad;
  } ctrlStrobe_s;

endpackage

// File: rtl/exec_shifter.sv
module exec_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0] dataIn,
  input  logic [W-1:0] amount,
  output logic [W-1:0] dataOut
);
  localparam int SHW = $clog2(W);

  logic          goRight;
  logic [W-1:0]  magnitude;
  logic          outOfRange;
  logic [SHW-1:0] shAmt;

  always_comb begin
    goRight    = amount[W-1];
    magnitude  = goRight ? (~amount + 1'b1) : amount;
    outOfRange = (magnitude >= W[W-1:0]);
    shAmt      = magnitude[SHW-1:0];
    if (goRight) begin
      dataOut = outOfRange ? {W{dataIn[W-1]}} : W'($signed(dataIn) >>> shAmt);
    end else begin
      dataOut = outOfRange ? '0 : (dataIn << shAmt);
    end
  end
endmodule

// File: rtl/exec_control.sv
module exec_control
  import exec_pkg::*;
(
  input  logic [3:0]  op,
  output ctrlStrobe_s strobes
);
  always_comb begin
    strobes = '{resSel: RS_ZERO, logicOp: LG_AND, doSub: 1'b0, cmpSigned: 1'b0,
                useImm6: 1'b0, immSource: 1'b0, shiftLoad: 1'b0};
    case (op)
      OP_ADD:   strobes.resSel = RS_ARITH;
      OP_SUB:   begin strobes.resSel = RS_ARITH; strobes.doSub = 1'b1; end
      OP_AND:   begin strobes.resSel = RS_LOGIC; strobes.logicOp = LG_AND; end
      OP_OR:    begin strobes.resSel = RS_LOGIC; strobes.logicOp = LG_OR;  end
      OP_XOR:   begin strobes.resSel = RS_LOGIC; strobes.logicOp = LG_XOR; end
      OP_SHF:   strobes.resSel = RS_SHIFT;
      OP_SLT:   begin strobes.resSel = RS_CMP; strobes.cmpSigned = 1'b1; end
      OP_SLTU:  strobes.resSel = RS_CMP;
      OP_LDI:   strobes.resSel = RS_IMM;
      OP_SHLDI: begin strobes.resSel = RS_IMM; strobes.shiftLoad = 1'b1; end
      OP_ADDI:  begin
        strobes.resSel    = RS_ARITH;
        strobes.useImm6   = 1'b1;
        strobes.immSource = 1'b1;
      end
      OP_SHFI:  begin
        strobes.resSel    = RS_SHIFT;
        strobes.useImm6   = 1'b1;
        strobes.immSource = 1'b1;
      end
      default:  strobes.resSel = RS_ZERO;
    endcase
  end
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 8,
  parameter int SIMM_W = 6
) (
  input  ctrlStrobe_s      strobes,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     opB,
  input  logic [W-1:0]     oldRd,
  input  logic [IMM_W-1:0] imm8,
  input  logic             srcPair,
  output logic [W-1:0]     result
);
  logic [W-1:0] srcVal;
  logic [W-1:0] immExt;
  logic [W-1:0] operandB;
  logic [W-1:0] arithRes;
  logic [W-1:0] logicRes;
  logic [W-1:0] shiftRes;
  logic [W-1:0] cmpRes;
  logic [W-1:0] immRes;
  logic         lessThan;

  always_comb begin
    immExt   = {{(W-SIMM_W){imm8[SIMM_W-1]}}, imm8[SIMM_W-1:0]};
    srcVal   = (strobes.immSource && !srcPair) ? oldRd : opA;
    operandB = strobes.useImm6 ? immExt : opB;
  end

  always_comb begin
    arithRes = srcVal + (strobes.doSub ? ~operandB : operandB) + W'(strobes.doSub);
  end

  always_comb begin
    case (strobes.logicOp)
      LG_AND:  logicRes = srcVal & operandB;
      LG_OR:   logicRes = srcVal | operandB;
      default: logicRes = srcVal ^ operandB;
    endcase
  end

  exec_shifter #(.W(W)) i_shifter (
    .dataIn (srcVal),
    .amount (operandB),
    .dataOut(shiftRes)
  );

  always_comb begin
    if (strobes.cmpSigned) lessThan = ($signed(srcVal) < $signed(operandB));
    else                   lessThan = (srcVal < operandB);
    cmpRes = {{(W-1){1'b0}}, lessThan};
  end

  always_comb begin
    immRes = {{(W-IMM_W){1'b0}}, imm8};
    if (strobes.shiftLoad) immRes = (oldRd << IMM_W) + immRes;
  end

  always_comb begin
    case (strobes.resSel)
      RS_ARITH: result = arithRes;
      RS_LOGIC: result = logicRes;
      RS_SHIFT: result = shiftRes;
      RS_CMP:   result = cmpRes;
      RS_IMM:   result = immRes;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int W      = 32,
  parameter int IMM_W  = 8,
  parameter int SIMM_W = 6
) (
  input  logic [3:0]       op,
  input  logic [W-1:0]     opA,
  input  logic [W-1:0]     opB,
  input  logic [W-1:0]     oldRd,
  input  logic [IMM_W-1:0] imm8,
  input  logic             srcPair,
  output logic [W-1:0]     result
);
  ctrlStrobe_s strobes;

  exec_control i_control (
    .op     (op),
    .strobes(strobes)
  );

  exec_datapath #(.W(W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) i_datapath (
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .oldRd  (oldRd),
    .imm8   (imm8),
    .srcPair(srcPair),
    .result (result)
  );
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int W      = 32,
  parameter int IMM_W  = 8,
  parameter int SIMM_W = 6
) (
  input logic [3:0]       op,
  input logic [W-1:0]     opA,
  input logic [W-1:0]     opB,
  input logic [W-1:0]     oldRd,
  input logic [IMM_W-1:0] imm8,
  input logic             srcPair,
  input logic [W-1:0]     result
);
  logic known;
  logic [W-1:0] immSrc;

  always_comb begin
    known  = !$isunknown({op, opA, opB, oldRd, imm8, srcPair, result});
    immSrc = srcPair ? opA : oldRd;

    if (known && op == 4'd1)
      assert_sub_inverse_R1: assert (result + opB == opA)
        else $error("subtract result does not invert");

    if (known && op == 4'd4)
      assert_xor_shape_R2: assert (result == ((opA | opB) & ~(opA & opB)))
        else $error("xor result malformed");

    if (known && op == 4'd5 && opB == '0)
      assert_zero_shift_R3: assert (result == opA)
        else $error("zero shift changed operand");

    if (known && (op == 4'd6 || op == 4'd7))
      assert_cmp_single_bit_R5: assert (result[W-1:1] == '0)
        else $error("compare result wider than one bit");

    if (known && op == 4'd8)
      assert_ldi_zero_ext_R6: assert (result[W-1:IMM_W] == '0 && result[IMM_W-1:0] == imm8)
        else $error("load immediate not zero extended");

    if (known && op == 4'd9)
      assert_shld_low_byte_R7: assert (result[IMM_W-1:0] == imm8 && result[W-1:IMM_W] == oldRd[W-IMM_W-1:0])
        else $error("shift-and-load malformed");

    if (known && op == 4'd10)
      assert_addi_src_R8: assert (result - {{(W-SIMM_W){imm8[SIMM_W-1]}}, imm8[SIMM_W-1:0]} == immSrc)
        else $error("immediate add wrong");

    if (known && op >= 4'd12)
      assert_unassigned_zero_R11: assert (result == '0)
        else $error("unassigned code gave nonzero");
  end
endmodule

bind exec_unit exec_unit_chk #(.W(W), .IMM_W(IMM_W), .SIMM_W(SIMM_W)) i_chk (
  .op(op), .opA(opA), .opB(opB), .oldRd(oldRd), .imm8(imm8),
  .srcPair(srcPair), .result(result)
);

// File: tb/test_exec_unit.sv
module test_exec_unit;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opA = '0, opB = '0, oldRd = '0;
  logic [7:0]  imm8 = '0;
  logic        srcPair = 1'b0;
  logic [31:0] result;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exec_unit i_exec_unit (
    .op(op), .opA(opA), .opB(opB), .oldRd(oldRd), .imm8(imm8),
    .srcPair(srcPair), .result(result)
  );

  function automatic logic [31:0] refShift(logic [31:0] v, logic [31:0] amt);
    logic [31:0] r = v;
    longint mag;
    bit right = amt[31];
    mag = right ? (longint'(1) << 32) - longint'(amt) : longint'(amt);
    for (int i = 0; i < 40; i++) begin
      if (i < mag) r = right ? {r[31], r[31:1]} : {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [31:0] refModel(logic [3:0] c, logic [31:0] a, logic [31:0] b,
                                           logic [31:0] rd, logic [7:0] im, logic sp);
    logic [31:0] s6 = {{26{im[5]}}, im[5:0]};
    logic [31:0] src = sp ? a : rd;
    case (c)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return refShift(a, b);
      4'd6:  return {31'd0, ($signed(a) < $signed(b))};
      4'd7:  return {31'd0, (a < b)};
      4'd8:  return {24'd0, im};
      4'd9:  return {rd[23:0], im};
      4'd10: return src + s6;
      4'd11: return refShift(src, s6);
      default: return 32'd0;
    endcase
  endfunction

  task automatic runOp(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] rd, input logic [7:0] im, input logic sp,
                       input string req);
    logic [31:0] exp;
    @(negedge clk);
    op = c; opA = a; opB = b; oldRd = rd; imm8 = im; srcPair = sp;
    exp = refModel(c, a, b, rd, im, sp);
    #1;
    testsRun++;
    if (result !== exp) begin
      testsFailed++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, c, result, exp);
    end
  endtask

  task automatic expectVal(input logic [31:0] exp, input string req);
    testsRun++;
    if (result !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, result, exp);
    end
  endtask

  initial begin
    #40000;
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [31:0] acc;
    void'($urandom(32'd20071));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    expectVal(32'd0, "R1 idle state");

    // R1 wrap
    runOp(4'd0, 32'hFFFF_FFFF, 32'd2, 32'h5, 8'h0, 1'b0, "R1");
    runOp(4'd1, 32'd0, 32'd1, 32'h5, 8'h0, 1'b0, "R1");
    // R2
    runOp(4'd2, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h0, 8'h0, 1'b0, "R2");
    runOp(4'd3, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h0, 8'h0, 1'b0, "R2");
    runOp(4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h0, 8'h0, 1'b0, "R2");
    // R3 directions
    runOp(4'd5, 32'h8000_0010, 32'd4, 32'h0, 8'h0, 1'b0, "R3");
    runOp(4'd5, 32'h8000_0010, 32'hFFFF_FFFF, 32'h0, 8'h0, 1'b0, "R3");
    runOp(4'd5, 32'h8000_0010, 32'hFFFF_FFE1, 32'h0, 8'h0, 1'b0, "R3");
    runOp(4'd5, 32'h1234_5678, 32'd0, 32'h0, 8'h0, 1'b0, "R3");
    runOp(4'd5, 32'h0000_0001, 32'd31, 32'h0, 8'h0, 1'b0, "R3");
    // R4 saturation
    runOp(4'd5, 32'hFFFF_FFFF, 32'd32, 32'h0, 8'h0, 1'b0, "R4");
    runOp(4'd5, 32'h8000_0000, 32'hFFFF_FFE0, 32'h0, 8'h0, 1'b0, "R4");
    runOp(4'd5, 32'h7FFF_FFFF, 32'hFFFF_FFE0, 32'h0, 8'h0, 1'b0, "R4");
    runOp(4'd5, 32'h8765_4321, 32'h8000_0000, 32'h0, 8'h0, 1'b0, "R4");
    runOp(4'd5, 32'h8765_4321, 32'd1000, 32'h0, 8'h0, 1'b0, "R4");
    // R5 signed vs unsigned
    runOp(4'd6, 32'h8000_0000, 32'd1, 32'h0, 8'h0, 1'b0, "R5");
    runOp(4'd7, 32'h8000_0000, 32'd1, 32'h0, 8'h0, 1'b0, "R5");
    runOp(4'd6, 32'd5, 32'd5, 32'h0, 8'h0, 1'b0, "R5");
    // R6
    runOp(4'd8, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 8'hC3, 1'b0, "R6");
    // R7 constant build
    runOp(4'd8, 32'h0, 32'h0, 32'hDEAD_BEEF, 8'h87, 1'b0, "R7");
    acc = result;
    runOp(4'd9, 32'h0, 32'h0, acc, 8'h65, 1'b0, "R7"); acc = result;
    runOp(4'd9, 32'h0, 32'h0, acc, 8'h43, 1'b0, "R7"); acc = result;
    runOp(4'd9, 32'h0, 32'h0, acc, 8'h21, 1'b0, "R7");
    expectVal(32'h8765_4321, "R7 constant");
    // R8 / R10 immediate add with both sources, top bits ignored
    runOp(4'd10, 32'd100, 32'h0, 32'd7, 8'hFF, 1'b0, "R8 R10");
    runOp(4'd10, 32'd100, 32'h0, 32'd7, 8'h3F, 1'b1, "R8 R10");
    runOp(4'd10, 32'd100, 32'h0, 32'd7, 8'hDF, 1'b1, "R8");
    // R9 / R10 immediate shift
    runOp(4'd11, 32'hC000_0000, 32'h0, 32'h0000_0003, 8'h1F, 1'b0, "R9 R10");
    runOp(4'd11, 32'hC000_0000, 32'h0, 32'h0000_0003, 8'h3F, 1'b1, "R9 R10");
    runOp(4'd11, 32'hC000_0000, 32'h0, 32'h0000_0003, 8'h20, 1'b1, "R9");
    // R10 oldRd ignored for register op
    runOp(4'd0, 32'd10, 32'd20, 32'hFFFF_0000, 8'h0, 1'b1, "R10");
    // R11 unassigned codes
    for (int c = 12; c < 16; c++)
      runOp(4'(c), 32'hABCD_0123, 32'h1, 32'h9, 8'h55, 1'b1, "R11");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  rc = 4'($urandom_range(0, 15));
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      if (rc == 4'd5 && $urandom_range(0, 1) == 1)
        rb = 32'($signed(7'($urandom_range(0, 127))));
      runOp(rc, ra, rb, $urandom, 8'($urandom), 1'($urandom), "R1 R3 R5 R8 R9 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule